// File: doc/BRIEF.md
# Predicated 32-bit ALU with condition flags

This block is the single-cycle execute stage of a data path for sixteen integer operations: bitwise, move, add and subtract, reverse subtract, and add and subtract that take the carry in. Operand B arrives already shifted or rotated. A four-bit condition code tests the incoming N, Z, C, V flags and decides whether the operation takes effect. If the condition fails, the register-write enable stays low and the flags pass through unchanged.

Four of the opcodes are test-only forms. They compute a bitwise AND, a bitwise XOR, a subtract or an add, update flags only, and never request a register write. The block returns the result, the write enable, and the next flag values as combinational outputs. A flag register inside the block captures those next values on the clock edge only when the condition passes and the set-flags input is high.

Top module: `cond_alu`

## Requirements
- R1: Opcodes 0000, 0001, 1100, 1110, 1101 and 1111 give A AND B, A XOR B, A OR B, A AND NOT B, B, and NOT B. Opcodes 1000 and 1001 give A AND B and A XOR B on `result`.
- R2: Opcodes 0010 (A-B), 0011 (B-A), 0100 (A+B), 0101 (A+B+C), 0110 (A-B-!C), 0111 (B-A-!C), 1010 (A-B) and 1011 (A+B) give the stated result modulo 2^32.
- R3: Opcodes 1000 to 1011 never raise `wr_en`. Every other opcode raises `wr_en` exactly when the condition passes.
- R4: For an update, N is result bit 31 and Z is set when the 32-bit result is zero.
- R5: For the add forms, C is the carry out of bit 31. For the subtract forms, C is set when no borrow occurs over the whole subtraction, including the extra one that the carry forms subtract when C is clear.
- R6: For the add forms, V is set when both addends have the same sign and the result sign differs. For the subtract forms, V is set when the operands differ in sign and the result sign differs from the minuend.
- R7: For the bitwise and move forms, V is kept. C is kept too, except when `imm_form` is high and B is above 255; then C takes B bit 31.
- R8: Condition codes 0 to 13 test Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), and Z|(N!=V).
- R9: Condition code 14 always passes and code 15 never passes.
- R10: When the condition fails, `wr_en` is low, `flags_nxt` equals `flags_in`, and `flags_q` holds its value.
- R11: `flags_nxt` equals `flags_in` when `set_flags` is low. `flags_q` loads `flags_nxt` on a rising edge only when the condition passes and `set_flags` is high; otherwise it holds.
- R12: Reset clears `flags_q` to 0000. Reset asserts asynchronously and releases on the clock.

Flag vectors are ordered {N, Z, C, V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update |
| cond | input | 4 | Condition code |
| imm_form | input | 1 | Operand B came from an immediate |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register write enable |
| flags_nxt | output | 4 | Next flag values {N,Z,C,V} |
| flags_q | output | 4 | Registered flag state |

## Verification
Condition evaluation and the carry-chained arithmetic read the same incoming C flag in one cycle. For example, an add-with-carry predicated on CS or HI both gates on C and consumes it as the carry input. The same edge can then load a carry produced from that input into the flag register. The sweep crosses every opcode with every condition, every flag vector, both set-flags values, both operand forms, and operands chosen at the sign, overflow and 255/256 boundaries. The output and the registered flags are judged against a 64-bit signed and unsigned reference computed separately in the bench.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND    = 4'h0,
    OP_XOR    = 4'h1,
    OP_SUB    = 4'h2,
    OP_RSUB   = 4'h3,
    OP_ADD    = 4'h4,
    OP_ADDC   = 4'h5,
    OP_SUBC   = 4'h6,
    OP_RSUBC  = 4'h7,
    OP_TSTAND = 4'h8,
    OP_TSTXOR = 4'h9,
    OP_CMPSUB = 4'hA,
    OP_CMPADD = 4'hB,
    OP_OR     = 4'hC,
    OP_MOVE   = 4'hD,
    OP_CLR    = 4'hE,
    OP_NOT    = 4'hF
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_ZSET  = 4'h0,
    CC_ZCLR  = 4'h1,
    CC_CSET  = 4'h2,
    CC_CCLR  = 4'h3,
    CC_NSET  = 4'h4,
    CC_NCLR  = 4'h5,
    CC_VSET  = 4'h6,
    CC_VCLR  = 4'h7,
    CC_UGT   = 4'h8,
    CC_ULE   = 4'h9,
    CC_SGE   = 4'hA,
    CC_SLT   = 4'hB,
    CC_SGT   = 4'hC,
    CC_SLE   = 4'hD,
    CC_ALL   = 4'hE,
    CC_NONE  = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_test(input alu_op_e op);
    return (op[3:2] == 2'b10);
  endfunction

  function automatic logic op_is_arith(input alu_op_e op);
    return (op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC,
                       OP_RSUBC, OP_CMPSUB, OP_CMPADD});
  endfunction

endpackage

// File: rtl/cond_alu_rst_sync.sv
module cond_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cond_alu_cond_eval.sv
module cond_alu_cond_eval
  import cond_alu_pkg::*;
(
  input  flags_t     flg,
  input  logic [3:0] cc,
  output logic       pass
);
  logic nv_eq;

  always_comb begin
    nv_eq = (flg.n == flg.v);
    unique case (cond_e'(cc))
      CC_ZSET: pass = flg.z;
      CC_ZCLR: pass = !flg.z;
      CC_CSET: pass = flg.c;
      CC_CCLR: pass = !flg.c;
      CC_NSET: pass = flg.n;
      CC_NCLR: pass = !flg.n;
      CC_VSET: pass = flg.v;
      CC_VCLR: pass = !flg.v;
      CC_UGT:  pass = flg.c && !flg.z;
      CC_ULE:  pass = !flg.c || flg.z;
      CC_SGE:  pass = nv_eq;
      CC_SLT:  pass = !nv_eq;
      CC_SGT:  pass = !flg.z && nv_eq;
      CC_SLE:  pass = flg.z || !nv_eq;
      CC_ALL:  pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  // R9: the unconditional codes ignore the flags entirely
  always_comb begin
    if (cc == 4'hE) p_always_pass_r9: assert (pass);
    if (cc == 4'hF) p_never_pass_r9: assert (!pass);
  end
endmodule

// File: rtl/cond_alu_core.sv
module cond_alu_core
  import cond_alu_pkg::*;
#(
  parameter int W         = 32,
  parameter int IMM_LIMIT = 255
) (
  input  logic [3:0]   op_code,
  input  logic         imm_form,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  flags_t       flg_in,
  output logic [W-1:0] res,
  output flags_t       flg_calc
);
  localparam int            MSB     = W - 1;
  localparam logic [W-1:0]  IMM_MAX = W'(IMM_LIMIT);

  alu_op_e      op;
  logic         swap;
  logic         sub_op;
  logic         cin;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W-1:0] y_eff;
  logic [W:0]   sum;
  logic         wide_imm;

  assign op = alu_op_e'(op_code);

  // operand routing and the shared adder
  always_comb begin
    swap   = (op == OP_RSUB) || (op == OP_RSUBC);
    sub_op = op inside {OP_SUB, OP_RSUB, OP_SUBC, OP_RSUBC, OP_CMPSUB};
    x      = swap ? b : a;
    y      = swap ? a : b;
    y_eff  = sub_op ? ~y : y;
    unique case (op)
      OP_SUB, OP_RSUB, OP_CMPSUB:  cin = 1'b1;
      OP_ADDC, OP_SUBC, OP_RSUBC:  cin = flg_in.c;
      default:                     cin = 1'b0;
    endcase
    sum = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
  end

  // result select
  always_comb begin
    unique case (op)
      OP_AND, OP_TSTAND: res = a & b;
      OP_XOR, OP_TSTXOR: res = a ^ b;
      OP_OR:             res = a | b;
      OP_MOVE:           res = b;
      OP_CLR:            res = a & ~b;
      OP_NOT:            res = ~b;
      default:           res = sum[W-1:0];
    endcase
  end

  // flag calculation
  always_comb begin
    wide_imm   = imm_form && (b > IMM_MAX);
    flg_calc.n = res[MSB];
    flg_calc.z = (res == '0);
    if (op_is_arith(op)) begin
      flg_calc.c = sum[W];
      flg_calc.v = (x[MSB] == y_eff[MSB]) && (res[MSB] != x[MSB]);
    end else begin
      flg_calc.c = wide_imm ? b[MSB] : flg_in.c;
      flg_calc.v = flg_in.v;
    end
  end

  // R5: a plain subtract reports no-borrow as an unsigned compare
  always_comb begin
    if (op == OP_SUB && !$isunknown({a, b}))
      p_sub_noborrow_r5: assert (flg_calc.c == (a >= b));
  end
endmodule

// File: rtl/cond_alu_flag_reg.sv
module cond_alu_flag_reg
  import cond_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  flags_t q_nxt;

  always_comb begin
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int W         = 32,
  parameter int IMM_LIMIT = 255,
  parameter int SYNC_LEN  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_code,
  input  logic         set_flags,
  input  logic [3:0]   cond,
  input  logic         imm_form,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_nxt,
  output logic [3:0]   flags_q
);
  logic   rst_sync_n;
  logic   pass;
  logic   upd;
  flags_t flg_cur;
  flags_t flg_calc;
  flags_t flg_sel;
  flags_t flg_reg;

  assign flg_cur = flags_t'(flags_in);

  cond_alu_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cond_alu_cond_eval u_cond (
    .flg  (flg_cur),
    .cc   (cond),
    .pass (pass)
  );

  cond_alu_core #(.W(W), .IMM_LIMIT(IMM_LIMIT)) u_core (
    .op_code  (op_code),
    .imm_form (imm_form),
    .a        (opnd_a),
    .b        (opnd_b),
    .flg_in   (flg_cur),
    .res      (result),
    .flg_calc (flg_calc)
  );

  always_comb begin
    upd     = pass && set_flags;
    flg_sel = upd ? flg_calc : flg_cur;
    wr_en   = pass && !op_is_test(alu_op_e'(op_code));
  end

  cond_alu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (upd),
    .d     (flg_sel),
    .q     (flg_reg)
  );

  assign flags_nxt = flg_sel;
  assign flags_q   = flg_reg;

  p_test_no_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code[3:2] == 2'b10) |-> !wr_en);

  p_fail_passthru_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en && !op_code[3] |-> (flags_nxt == flags_in));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flags_nxt == flags_in) |=> (flags_q == $past(flags_in)) || $stable(flags_q));

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pass && set_flags) |=> (flags_q == $past(flags_nxt)));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pass && set_flags) |-> (flags_nxt[2] == (result == '0)) && (flags_nxt[3] == result[W-1]));

  p_logic_keeps_v_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) |-> (flags_nxt[0] == flags_in[0]));
endmodule

// File: tb/cond_alu_tb.sv
module cond_alu_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_code;
  logic        set_flags;
  logic [3:0]  cond;
  logic        imm_form;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_nxt;
  logic [3:0]  flags_q;

  int total;
  int bad;
  bit finished;

  cond_alu u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .set_flags (set_flags),
    .cond      (cond),
    .imm_form  (imm_form),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .result    (result),
    .wr_en     (wr_en),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q)
  );

  // 100 MHz: 10 time units of 1 ns per period
  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h op=%h cc=%h f=%h s=%0b imm=%0b a=%h b=%h",
               tag, act, exp, op_code, cond, flags_in, set_flags, imm_form, opnd_a, opnd_b);
    end
  endtask

  // R8, R9: condition table
  function automatic bit ref_pass(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reference result and flags from wide signed/unsigned arithmetic
  task automatic ref_op(input logic [3:0] op, input bit imm, input logic [31:0] a,
                        input logic [31:0] b, input logic [3:0] f,
                        output logic [31:0] r, output logic [3:0] fo);
    longint ua, ub, sa, sb, cbit, wide, sw, ux, uy, sx, sy;
    bit cf, vf, arith;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    cbit = longint'(f[1]);
    cf = f[1];
    vf = f[0];
    arith = 1'b1;
    r = 32'h0;
    case (op)
      4'h2, 4'h3, 4'h6, 4'h7, 4'hA: begin
        longint bw;
        bw = (op == 4'h6 || op == 4'h7) ? (1 - cbit) : 0;
        if (op == 4'h3 || op == 4'h7) begin
          ux = ub; uy = ua; sx = sb; sy = sa;
        end else begin
          ux = ua; uy = ub; sx = sa; sy = sb;
        end
        wide = ux - uy - bw;
        r = wide[31:0];
        cf = (ux >= uy + bw);
        sw = sx - sy - bw;
        vf = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
      end
      4'h4, 4'h5, 4'hB: begin
        longint ci;
        ci = (op == 4'h5) ? cbit : 0;
        wide = ua + ub + ci;
        r = wide[31:0];
        cf = wide[32];
        sw = sa + sb + ci;
        vf = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
      end
      default: begin
        arith = 1'b0;
        case (op)
          4'h0, 4'h8: r = a & b;
          4'h1, 4'h9: r = a ^ b;
          4'hC:       r = a | b;
          4'hD:       r = b;
          4'hE:       r = a & ~b;
          default:    r = ~b;
        endcase
        if (imm && (ub > 255)) cf = b[31];
      end
    endcase
    fo = {r[31], (r == 32'h0), cf, vf};
  endtask

  initial begin
    logic [31:0] pa [7];
    logic [31:0] pb [7];
    logic [3:0]  model_q;
    finished = 1'b0;
    total = 0;
    bad = 0;
    pa[0] = 32'h7FFF_FFFF; pb[0] = 32'h0000_0001;
    pa[1] = 32'h8000_0000; pb[1] = 32'h0000_0001;
    pa[2] = 32'h0000_0005; pb[2] = 32'h0000_0005;
    pa[3] = 32'h0000_0000; pb[3] = 32'hFFFF_FFFF;
    pa[4] = 32'h0F0F_00FF; pb[4] = 32'h0000_00FF;
    pa[5] = 32'hFFFF_FFFF; pb[5] = 32'h0000_0100;
    pa[6] = 32'h1234_5678; pb[6] = 32'h8000_0100;

    rst_n = 1'b0;
    op_code = 4'h0; set_flags = 1'b0; cond = 4'hF; imm_form = 1'b0;
    opnd_a = '0; opnd_b = '0; flags_in = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(flags_q == 4'h0, "R12 reset flags", {28'b0, flags_q}, 32'h0);
    model_q = 4'h0;

    for (int op = 0; op < 16; op++) begin
      for (int cc = 0; cc < 16; cc++) begin
        for (int fl = 0; fl < 16; fl++) begin
          for (int s = 0; s < 2; s++) begin
            for (int im = 0; im < 2; im++) begin
              for (int p = 0; p < 7; p++) begin
                logic [31:0] er;
                logic [3:0]  ef;
                logic [3:0]  enx;
                bit          ep, ew, is_test;
                @(negedge clk);
                op_code = 4'(op); cond = 4'(cc); flags_in = 4'(fl);
                set_flags = s[0]; imm_form = im[0];
                opnd_a = pa[p]; opnd_b = pb[p];
                ref_op(4'(op), im[0], pa[p], pb[p], 4'(fl), er, ef);
                ep = ref_pass(4'(cc), 4'(fl));
                is_test = (op >= 8) && (op <= 11);
                ew = ep && !is_test;
                enx = (ep && s[0]) ? ef : 4'(fl);
                #1;
                if (op inside {0, 1, 8, 9, 12, 13, 14, 15})
                  chk(result == er, "R1 result", result, er);
                else
                  chk(result == er, "R2 result", result, er);
                if (is_test)
                  chk(wr_en == 1'b0, "R3 test op write", {31'b0, wr_en}, 32'h0);
                else if (cc >= 14)
                  chk(wr_en == ew, "R9 always/never", {31'b0, wr_en}, {31'b0, ew});
                else
                  chk(wr_en == ew, "R8 condition", {31'b0, wr_en}, {31'b0, ew});
                if (!ep)
                  chk(flags_nxt == enx, "R10 fail keeps flags", {28'b0, flags_nxt}, {28'b0, enx});
                else if (!s[0])
                  chk(flags_nxt == enx, "R11 no set keeps flags", {28'b0, flags_nxt}, {28'b0, enx});
                else begin
                  chk(flags_nxt[3:2] == enx[3:2], "R4 N/Z", {30'b0, flags_nxt[3:2]}, {30'b0, enx[3:2]});
                  if (op inside {2, 3, 4, 5, 6, 7, 10, 11}) begin
                    chk(flags_nxt[1] == enx[1], "R5 carry", {31'b0, flags_nxt[1]}, {31'b0, enx[1]});
                    chk(flags_nxt[0] == enx[0], "R6 overflow", {31'b0, flags_nxt[0]}, {31'b0, enx[0]});
                  end else
                    chk(flags_nxt[1:0] == enx[1:0], "R7 logic C/V", {30'b0, flags_nxt[1:0]}, {30'b0, enx[1:0]});
                end
                if (ep && s[0]) model_q = ef;
                @(posedge clk);
                #1;
                chk(flags_q == model_q, "R11 flag register", {28'b0, flags_q}, {28'b0, model_q});
              end
            end
          end
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule